// File: doc/BRIEF.md
# Pipeline Hazard and Operand Forwarding Controller

This block sits beside the decode stage of a single-issue, in-order, five-stage pipeline. It has the fetch, decode, execute, memory and write-back stages. Each cycle it receives the register numbers, valid bits and instruction classes of the instructions in decode, execute, memory and write-back. It also receives a busy flag from the multi-cycle multiply unit. From these it decides two things: whether the front end (fetch and decode) must hold for a cycle, and where each operand of the instruction in execute should be read from. The choices are the register file, the memory-stage result or the write-back result.

The execute stage has three register read ports, A, B and C. Port C is 128 bits wide, so a paired store can move two consecutive registers in one access. Port C therefore has two independent forwarding selects, one for each 64-bit half. The block stalls in four cases:

- a load followed by a dependent instruction;
- a store waiting behind any older control-flow instruction;
- a consumer of a multiply result that is not ready yet, with separate latencies for the full and the fast multiplier;
- a new multiply while the multiplier is busy.

The link register is written only when a branch-and-link reaches write-back. An execute-stage instruction that is later squashed can therefore never change the link register.

Top module: `hz_ctrl`

## Requirements
- R1: For each operand of a valid execute-stage instruction, the select is 1 (memory stage) when a valid memory-stage instruction has a destination equal to that operand's register. Otherwise it is 2 (write-back) when a valid write-back instruction matches. Otherwise it is 0 (register file). When both stages match, the memory stage wins.
- R2: The low half of port C uses register rc. The high half uses rc+1 modulo 64, but only when the execute class is paired store (class code 3). For every other class, including plain store (class 2), the high-half select is 0. Both halves follow the rule of R1.
- R3: A valid decode instruction stalls in any cycle where a valid load (class 1) in execute writes a register that the decode instruction reads. The registers read are ra, rb and rc, plus rc+1 for a paired store.
- R4: A store (class 2) or paired store (class 3) in decode stalls while execute, memory or write-back holds a valid branch (class 4) or branch-and-link (class 5).
- R5: Let a full multiply or divide (class 6) occupy execute in cycle t. A decode instruction reading its destination then stalls in cycles t through t+FULL_LAT-2 (17 cycles by default). For a fast multiply (class 7) the stall covers t through t+FAST_LAT-2 (2 cycles by default). Readers of other registers do not stall.
- R6: A multiply instruction (class 6 or 7) in decode stalls while mul_busy is high. Other classes ignore mul_busy.
- R7: lk_we is 1 exactly when write-back holds a valid branch-and-link (class 5). A branch-and-link in execute never raises it.
- R8: Register 0 never matches. It produces no forward, no load-use stall and no multiply stall.
- R9: An invalid stage takes no part. An invalid memory or write-back stage is never a forwarding source. An invalid execute stage gets all selects 0. An invalid decode stage never stalls.
- R10: Reset clears any pending multiply result. After reset, idle inputs give stall 0, all selects 0 and lk_we 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_cls | input | 3 | Decode instruction class |
| id_ra | input | 6 | Decode source A register |
| id_rb | input | 6 | Decode source B register |
| id_rc | input | 6 | Decode source C register |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_cls | input | 3 | Execute instruction class |
| ex_rd | input | 6 | Execute destination register, 0 for none |
| ex_ra | input | 6 | Execute source A register |
| ex_rb | input | 6 | Execute source B register |
| ex_rc | input | 6 | Execute source C register |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_cls | input | 3 | Memory-stage instruction class |
| mem_rd | input | 6 | Memory-stage destination register |
| wb_valid | input | 1 | Write-back stage holds an instruction |
| wb_cls | input | 3 | Write-back instruction class |
| wb_rd | input | 6 | Write-back destination register |
| mul_busy | input | 1 | Multiply unit cannot accept a new operation |
| stall | output | 1 | Hold fetch and decode, bubble into execute |
| sel_a | output | 2 | Port A source: 0 file, 1 memory, 2 write-back |
| sel_b | output | 2 | Port B source |
| sel_c_lo | output | 2 | Port C low-half source |
| sel_c_hi | output | 2 | Port C high-half source |
| lk_we | output | 1 | Link register write enable |

## Verification
Two functions can act in the same cycle. First, a store held in decode behind a branch-and-link in the memory stage can coincide with a second branch-and-link committing in write-back. The bench sets this up with one vector and expects stall and lk_we both at 1. Second, a paired store in execute can draw its two halves from different stages in the same cycle. The bench gives the memory stage destination rc+1 and write-back destination rc, and expects the high half to select memory and the low half to select write-back. The multiply windows are judged cycle by cycle against the latency count, including the first cycle after the window closes.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU    = 3'd0,
        CLS_LOAD   = 3'd1,
        CLS_STORE  = 3'd2,
        CLS_STPAIR = 3'd3,
        CLS_BRANCH = 3'd4,
        CLS_LINK   = 3'd5,
        CLS_MULL   = 3'd6,   // full multiply or divide
        CLS_MULS   = 3'd7    // fast multiply
    } icls_e;

    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_MEM = 2'd1,
        SRC_WB  = 2'd2
    } fsrc_e;

    typedef struct packed {
        logic load_use;
        logic store_wait;
        logic mul_use;
        logic mul_struct;
    } hz_cause_t;

    function automatic logic cls_is_ctrl(input logic [CLS_W-1:0] c);
        return (c == CLS_BRANCH) || (c == CLS_LINK);
    endfunction

    function automatic logic cls_is_store(input logic [CLS_W-1:0] c);
        return (c == CLS_STORE) || (c == CLS_STPAIR);
    endfunction

    function automatic logic cls_is_mul(input logic [CLS_W-1:0] c);
        return (c == CLS_MULL) || (c == CLS_MULS);
    endfunction

endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
    import hz_pkg::*;
#(
    parameter int REG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_valid,
    input  logic [REG_W-1:0] src_reg,
    input  logic             mem_valid,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             wb_valid,
    input  logic [REG_W-1:0] wb_rd,
    output logic [1:0]       sel
);

    logic live;
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        live    = use_valid && (src_reg != '0);
        mem_hit = live && mem_valid && (mem_rd == src_reg);
        wb_hit  = live && wb_valid && (wb_rd == src_reg);
        if (mem_hit) begin
            sel = SRC_MEM;      // younger result has priority
        end else if (wb_hit) begin
            sel = SRC_WB;
        end else begin
            sel = SRC_RF;
        end
    end

    p_zero_reg_rf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_reg == '0) |-> (sel == SRC_RF));

    p_wb_only_on_mem_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_WB) |-> !(mem_valid && (mem_rd == src_reg)));

    p_bubble_reads_rf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !use_valid |-> (sel == SRC_RF));

endmodule

// File: rtl/hz_mul_track.sv
module hz_mul_track
    import hz_pkg::*;
#(
    parameter int REG_W    = 6,
    parameter int FULL_LAT = 18,
    parameter int FAST_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ex_valid,
    input  logic [CLS_W-1:0] ex_cls,
    input  logic [REG_W-1:0] ex_rd,
    output logic             pend_valid,
    output logic [REG_W-1:0] pend_rd
);

    localparam int MAX_LAT = (FULL_LAT > FAST_LAT) ? FULL_LAT : FAST_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic [REG_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (ex_valid && (ex_cls == CLS_MULL)) begin
            trk_d.rd  = ex_rd;
            trk_d.cnt = CNT_W'(FULL_LAT - 2);
        end else if (ex_valid && (ex_cls == CLS_MULS)) begin
            trk_d.rd  = ex_rd;
            trk_d.cnt = CNT_W'(FAST_LAT - 2);
        end else if (trk_q.cnt != '0) begin
            trk_d.cnt = trk_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign pend_valid = (trk_q.cnt != '0);
    assign pend_rd    = trk_q.rd;

    p_full_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && (ex_cls == CLS_MULL)) |=> (trk_q.cnt == CNT_W'(FULL_LAT - 2)));

    p_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((trk_q.cnt != '0) && !(ex_valid && cls_is_mul(ex_cls)))
            |=> (trk_q.cnt == $past(trk_q.cnt) - 1'b1));

endmodule

// File: rtl/hz_stall.sv
module hz_stall
    import hz_pkg::*;
#(
    parameter int REG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [CLS_W-1:0] id_cls,
    input  logic [REG_W-1:0] id_ra,
    input  logic [REG_W-1:0] id_rb,
    input  logic [REG_W-1:0] id_rc,
    input  logic             ex_valid,
    input  logic [CLS_W-1:0] ex_cls,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             mem_valid,
    input  logic [CLS_W-1:0] mem_cls,
    input  logic             wb_valid,
    input  logic [CLS_W-1:0] wb_cls,
    input  logic             mul_busy,
    input  logic             pend_valid,
    input  logic [REG_W-1:0] pend_rd,
    output logic             stall
);

    function automatic logic reads_reg(
        input logic [REG_W-1:0] r,
        input logic [REG_W-1:0] a,
        input logic [REG_W-1:0] b,
        input logic [REG_W-1:0] c,
        input logic [REG_W-1:0] c_hi,
        input logic             pair
    );
        return (r != '0) && ((r == a) || (r == b) || (r == c) || (pair && (r == c_hi)));
    endfunction

    hz_cause_t        cause;
    logic [REG_W-1:0] id_rc_hi;
    logic             id_pair;
    logic             older_ctrl;

    always_comb begin
        id_rc_hi   = id_rc + REG_W'(1);
        id_pair    = (id_cls == CLS_STPAIR);
        older_ctrl = (ex_valid && cls_is_ctrl(ex_cls))
                  || (mem_valid && cls_is_ctrl(mem_cls))
                  || (wb_valid && cls_is_ctrl(wb_cls));

        cause.load_use   = ex_valid && (ex_cls == CLS_LOAD)
                        && reads_reg(ex_rd, id_ra, id_rb, id_rc, id_rc_hi, id_pair);
        cause.store_wait = cls_is_store(id_cls) && older_ctrl;
        cause.mul_use    = (ex_valid && cls_is_mul(ex_cls)
                            && reads_reg(ex_rd, id_ra, id_rb, id_rc, id_rc_hi, id_pair))
                        || (pend_valid
                            && reads_reg(pend_rd, id_ra, id_rb, id_rc, id_rc_hi, id_pair));
        cause.mul_struct = cls_is_mul(id_cls) && mul_busy;

        stall = id_valid && (|cause);
    end

    p_load_use_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && ex_valid && (ex_cls == CLS_LOAD) && (ex_rd != '0) && (ex_rd == id_ra))
            |-> stall);

    p_store_behind_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && cls_is_store(id_cls) && ex_valid && cls_is_ctrl(ex_cls)) |-> stall);

    p_busy_holds_mul_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && mul_busy && cls_is_mul(id_cls)) |-> stall);

    p_idle_decode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> !stall);

endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int REG_W    = 6,
    parameter int FULL_LAT = 18,
    parameter int FAST_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [2:0]       id_cls,
    input  logic [REG_W-1:0] id_ra,
    input  logic [REG_W-1:0] id_rb,
    input  logic [REG_W-1:0] id_rc,
    input  logic             ex_valid,
    input  logic [2:0]       ex_cls,
    input  logic [REG_W-1:0] ex_rd,
    input  logic [REG_W-1:0] ex_ra,
    input  logic [REG_W-1:0] ex_rb,
    input  logic [REG_W-1:0] ex_rc,
    input  logic             mem_valid,
    input  logic [2:0]       mem_cls,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             wb_valid,
    input  logic [2:0]       wb_cls,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             mul_busy,
    output logic             stall,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b,
    output logic [1:0]       sel_c_lo,
    output logic [1:0]       sel_c_hi,
    output logic             lk_we
);

    // operand slots: A, B, C low half, C high half (R2)
    localparam int NUM_OPS = 4;

    logic [REG_W-1:0] op_reg [NUM_OPS];
    logic             op_use [NUM_OPS];
    logic [1:0]       op_sel [NUM_OPS];

    always_comb begin
        op_reg[0] = ex_ra;
        op_reg[1] = ex_rb;
        op_reg[2] = ex_rc;
        op_reg[3] = ex_rc + REG_W'(1);
        op_use[0] = ex_valid;
        op_use[1] = ex_valid;
        op_use[2] = ex_valid;
        op_use[3] = ex_valid && (ex_cls == CLS_STPAIR);
    end

    for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_fwd
        hz_fwd_sel #(
            .REG_W (REG_W)
        ) u_sel (
            .clk       (clk),
            .rst_n     (rst_n),
            .use_valid (op_use[gi]),
            .src_reg   (op_reg[gi]),
            .mem_valid (mem_valid),
            .mem_rd    (mem_rd),
            .wb_valid  (wb_valid),
            .wb_rd     (wb_rd),
            .sel       (op_sel[gi])
        );
    end

    assign sel_a    = op_sel[0];
    assign sel_b    = op_sel[1];
    assign sel_c_lo = op_sel[2];
    assign sel_c_hi = op_sel[3];

    logic             pend_valid;
    logic [REG_W-1:0] pend_rd;

    hz_mul_track #(
        .REG_W    (REG_W),
        .FULL_LAT (FULL_LAT),
        .FAST_LAT (FAST_LAT)
    ) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .ex_valid   (ex_valid),
        .ex_cls     (ex_cls),
        .ex_rd      (ex_rd),
        .pend_valid (pend_valid),
        .pend_rd    (pend_rd)
    );

    hz_stall #(
        .REG_W (REG_W)
    ) u_stall (
        .clk        (clk),
        .rst_n      (rst_n),
        .id_valid   (id_valid),
        .id_cls     (id_cls),
        .id_ra      (id_ra),
        .id_rb      (id_rb),
        .id_rc      (id_rc),
        .ex_valid   (ex_valid),
        .ex_cls     (ex_cls),
        .ex_rd      (ex_rd),
        .mem_valid  (mem_valid),
        .mem_cls    (mem_cls),
        .wb_valid   (wb_valid),
        .wb_cls     (wb_cls),
        .mul_busy   (mul_busy),
        .pend_valid (pend_valid),
        .pend_rd    (pend_rd),
        .stall      (stall)
    );

    // link register commits only from write-back (R7)
    assign lk_we = wb_valid && (wb_cls == CLS_LINK);

    p_link_not_from_ex_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && (ex_cls == CLS_LINK) && !(wb_valid && (wb_cls == CLS_LINK))) |-> !lk_we);

endmodule

// File: tb/tb_hz_ctrl.sv
module tb_hz_ctrl;

    localparam int FULL_LAT = 18;
    localparam int FAST_LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       id_valid, ex_valid, mem_valid, wb_valid, mul_busy;
    logic [2:0] id_cls, ex_cls, mem_cls, wb_cls;
    logic [5:0] id_ra, id_rb, id_rc, ex_rd, ex_ra, ex_rb, ex_rc, mem_rd, wb_rd;
    logic       stall, lk_we;
    logic [1:0] sel_a, sel_b, sel_c_lo, sel_c_hi;

    int nchk = 0;
    int nbad = 0;

    always #10 clk = ~clk;   // 50 MHz

    hz_ctrl #(.REG_W(6), .FULL_LAT(FULL_LAT), .FAST_LAT(FAST_LAT)) dut (
        .clk(clk), .rst_n(rst_n),
        .id_valid(id_valid), .id_cls(id_cls), .id_ra(id_ra), .id_rb(id_rb), .id_rc(id_rc),
        .ex_valid(ex_valid), .ex_cls(ex_cls), .ex_rd(ex_rd), .ex_ra(ex_ra), .ex_rb(ex_rb),
        .ex_rc(ex_rc), .mem_valid(mem_valid), .mem_cls(mem_cls), .mem_rd(mem_rd),
        .wb_valid(wb_valid), .wb_cls(wb_cls), .wb_rd(wb_rd), .mul_busy(mul_busy),
        .stall(stall), .sel_a(sel_a), .sel_b(sel_b), .sel_c_lo(sel_c_lo),
        .sel_c_hi(sel_c_hi), .lk_we(lk_we)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       idv; logic [2:0] idc; logic [5:0] ira, irb, irc;
        logic       exv; logic [2:0] exc; logic [5:0] erd, era, erb, erc;
        logic       mv;  logic [2:0] mc;  logic [5:0] mrd;
        logic       wv;  logic [2:0] wc;  logic [5:0] wrd;
        logic       busy;
        logic       e_stall; logic [1:0] e_sa, e_sb, e_scl, e_sch; logic e_lk;
    } vec_t;

    function automatic vec_t mk(
        input int req,
        input int idv, input int idc, input int ira, input int irb, input int irc,
        input int exv, input int exc, input int erd, input int era, input int erb, input int erc,
        input int mv, input int mc, input int mrd,
        input int wv, input int wc, input int wrd,
        input int busy,
        input int es, input int sa, input int sb, input int scl, input int sch, input int lk
    );
        vec_t v;
        v.req = 4'(req);
        v.idv = 1'(idv); v.idc = 3'(idc); v.ira = 6'(ira); v.irb = 6'(irb); v.irc = 6'(irc);
        v.exv = 1'(exv); v.exc = 3'(exc); v.erd = 6'(erd);
        v.era = 6'(era); v.erb = 6'(erb); v.erc = 6'(erc);
        v.mv = 1'(mv); v.mc = 3'(mc); v.mrd = 6'(mrd);
        v.wv = 1'(wv); v.wc = 3'(wc); v.wrd = 6'(wrd);
        v.busy = 1'(busy);
        v.e_stall = 1'(es); v.e_sa = 2'(sa); v.e_sb = 2'(sb);
        v.e_scl = 2'(scl); v.e_sch = 2'(sch); v.e_lk = 1'(lk);
        return v;
    endfunction

    localparam int NVEC = 26;
    // req | id v,c,ra,rb,rc | ex v,c,rd,ra,rb,rc | mem v,c,rd | wb v,c,rd | busy | stall,sa,sb,scl,sch,lk
    localparam vec_t VEC [NVEC] = '{
        mk(1, 0,0,0,0,0,   1,0,9,3,4,0,   1,0,3,  1,0,4,  0, 0,1,2,0,0,0), // R1 mem + wb
        mk(1, 0,0,0,0,0,   1,0,9,5,5,0,   1,0,5,  1,0,5,  0, 0,1,1,0,0,0), // R1 mem wins
        mk(1, 0,0,0,0,0,   1,0,9,7,2,0,   1,0,8,  1,0,7,  0, 0,2,0,0,0,0), // R1 wb only
        mk(8, 0,0,0,0,0,   1,0,9,0,0,0,   1,0,0,  1,0,0,  0, 0,0,0,0,0,0), // R8 zero reg
        mk(9, 0,0,0,0,0,   1,0,9,3,4,0,   0,0,3,  0,0,4,  0, 0,0,0,0,0,0), // R9 bubbles
        mk(9, 0,0,0,0,0,   0,0,9,3,4,3,   1,0,3,  1,0,4,  0, 0,0,0,0,0,0), // R9 ex bubble
        mk(2, 0,0,0,0,0,   1,3,0,0,0,10,  1,0,11, 1,0,10, 0, 0,0,0,2,1,0), // R2 pair halves
        mk(2, 0,0,0,0,0,   1,2,0,0,0,10,  1,0,11, 1,0,10, 0, 0,0,0,2,0,0), // R2 plain store
        mk(2, 0,0,0,0,0,   1,3,0,0,0,63,  1,0,63, 1,0,1,  0, 0,0,0,1,0,0), // R2 wrap to 0
        mk(3, 1,0,12,0,0,  1,1,12,0,0,0,  0,0,0,  0,0,0,  0, 1,0,0,0,0,0), // R3 load-use
        mk(3, 1,3,0,0,11,  1,1,12,0,0,0,  0,0,0,  0,0,0,  0, 1,0,0,0,0,0), // R3 pair high
        mk(3, 1,0,13,14,0, 1,1,12,0,0,0,  0,0,0,  0,0,0,  0, 0,0,0,0,0,0), // R3 no match
        mk(9, 0,0,12,0,0,  1,1,12,0,0,0,  0,0,0,  0,0,0,  0, 0,0,0,0,0,0), // R9 id bubble
        mk(8, 1,0,0,0,0,   1,1,0,0,0,0,   0,0,0,  0,0,0,  0, 0,0,0,0,0,0), // R8 load to r0
        mk(4, 1,2,1,2,3,   1,4,0,0,0,0,   0,0,0,  0,0,0,  0, 1,0,0,0,0,0), // R4 ex branch
        mk(4, 1,2,1,2,3,   0,0,0,0,0,0,   1,5,0,  1,5,0,  0, 1,0,0,0,0,1), // R4 + R7 same cycle
        mk(4, 1,3,0,0,5,   0,0,0,0,0,0,   0,0,0,  1,4,0,  0, 1,0,0,0,0,0), // R4 wb branch
        mk(4, 1,2,1,2,3,   0,4,0,0,0,0,   0,0,0,  0,0,0,  0, 0,0,0,0,0,0), // R4 branch bubble
        mk(4, 1,0,1,2,3,   1,4,0,0,0,0,   0,0,0,  0,0,0,  0, 0,0,0,0,0,0), // R4 alu not held
        mk(7, 0,0,0,0,0,   0,0,0,0,0,0,   0,0,0,  0,5,0,  0, 0,0,0,0,0,0), // R7 wb link bubble
        mk(7, 0,0,0,0,0,   1,5,0,0,0,0,   0,0,0,  1,0,0,  0, 0,0,0,0,0,0), // R7 ex link
        mk(7, 0,0,0,0,0,   0,0,0,0,0,0,   0,0,0,  1,5,0,  0, 0,0,0,0,0,1), // R7 wb link
        mk(6, 1,6,1,2,0,   0,0,0,0,0,0,   0,0,0,  0,0,0,  1, 1,0,0,0,0,0), // R6 full busy
        mk(6, 1,7,1,2,0,   0,0,0,0,0,0,   0,0,0,  0,0,0,  1, 1,0,0,0,0,0), // R6 fast busy
        mk(6, 1,0,1,2,0,   0,0,0,0,0,0,   0,0,0,  0,0,0,  1, 0,0,0,0,0,0), // R6 alu ignores
        mk(6, 1,6,1,2,0,   0,0,0,0,0,0,   0,0,0,  0,0,0,  0, 0,0,0,0,0,0)  // R6 not busy
    };

    task automatic check(input int req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        id_valid = 0; id_cls = 0; id_ra = 0; id_rb = 0; id_rc = 0;
        ex_valid = 0; ex_cls = 0; ex_rd = 0; ex_ra = 0; ex_rb = 0; ex_rc = 0;
        mem_valid = 0; mem_cls = 0; mem_rd = 0;
        wb_valid = 0; wb_cls = 0; wb_rd = 0; mul_busy = 0;
    endtask

    task automatic apply(input vec_t v);
        id_valid = v.idv; id_cls = v.idc; id_ra = v.ira; id_rb = v.irb; id_rc = v.irc;
        ex_valid = v.exv; ex_cls = v.exc; ex_rd = v.erd; ex_ra = v.era; ex_rb = v.erb;
        ex_rc = v.erc; mem_valid = v.mv; mem_cls = v.mc; mem_rd = v.mrd;
        wb_valid = v.wv; wb_cls = v.wc; wb_rd = v.wrd; mul_busy = v.busy;
    endtask

    // R5: multiply in EX at k=0, consumer of r20 waits in decode
    task automatic mul_window(input logic [2:0] c, input int lat);
        @(negedge clk);
        idle();
        ex_valid = 1; ex_cls = c; ex_rd = 6'd20;
        id_valid = 1; id_cls = 3'd0; id_ra = 6'd20;
        for (int k = 0; k <= lat; k++) begin
            if (k > 0) begin
                @(negedge clk);
                ex_valid = 0; ex_cls = 0; ex_rd = 0;
            end
            #1;
            check(5, $sformatf("mul window cls=%0d k=%0d", c, k), int'(stall), int'(k <= lat - 2));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin : main
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        // R10 reset state
        check(10, "reset stall", int'(stall), 0);
        check(10, "reset sel_a", int'(sel_a), 0);
        check(10, "reset sel_c_hi", int'(sel_c_hi), 0);
        check(10, "reset lk_we", int'(lk_we), 0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            #1;
            check(int'(VEC[i].req), $sformatf("vec%0d stall", i), int'(stall), int'(VEC[i].e_stall));
            check(int'(VEC[i].req), $sformatf("vec%0d sel_a", i), int'(sel_a), int'(VEC[i].e_sa));
            check(int'(VEC[i].req), $sformatf("vec%0d sel_b", i), int'(sel_b), int'(VEC[i].e_sb));
            check(int'(VEC[i].req), $sformatf("vec%0d sel_c_lo", i), int'(sel_c_lo), int'(VEC[i].e_scl));
            check(int'(VEC[i].req), $sformatf("vec%0d sel_c_hi", i), int'(sel_c_hi), int'(VEC[i].e_sch));
            check(int'(VEC[i].req), $sformatf("vec%0d lk_we", i), int'(lk_we), int'(VEC[i].e_lk));
        end

        // R5 full and fast multiply windows
        mul_window(3'd6, FULL_LAT);
        mul_window(3'd7, FAST_LAT);

        // R5 unrelated register is not held during a full window
        @(negedge clk);
        idle(); ex_valid = 1; ex_cls = 3'd6; ex_rd = 6'd20;
        @(negedge clk);
        idle(); id_valid = 1; id_ra = 6'd21; id_rb = 6'd22;
        #1;
        check(5, "unrelated reader during window", int'(stall), 0);
        id_rc = 6'd20;
        #1;
        check(5, "C reader of pending result", int'(stall), 1);

        // R10 reset drops the pending result
        @(negedge clk);
        idle();
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        id_valid = 1; id_ra = 6'd20;
        #1;
        check(10, "pending cleared by reset", int'(stall), 0);

        // R8 multiply to r0 blocks no one
        @(negedge clk);
        idle(); ex_valid = 1; ex_cls = 3'd6; ex_rd = 6'd0; id_valid = 1;
        #1;
        check(8, "mul to r0 in ex", int'(stall), 0);
        @(negedge clk);
        ex_valid = 0; ex_cls = 0;
        #1;
        check(8, "mul to r0 pending", int'(stall), 0);

        @(negedge clk);
        idle();
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule